// File: doc/BRIEF.md
# Exponential Pitch-to-Delay Converter

This block turns a sampled control code, read as a pitch on a volt-per-octave scale, into a delay length in samples. The delay has eight fractional bits and can serve directly as the read offset of a fractional delay line. A higher code gives a shorter delay, and each 512 code steps halve the delay.

Every accepted code first passes through a one-pole low-pass smoother, which suppresses noise on the control input at the cost of control bandwidth. The smoothed value then splits into an octave number, a table index and a sub-step fraction. The index selects a pair of neighbouring entries in a 65-entry table that covers the lowest octave only. The pair is interpolated linearly, and the octave number shifts the result right with rounding. With the default base delay of 5859 samples, the range runs from about 61 ms down to about 0.24 ms at a 96 kHz sample rate.

Top module: `pitch_delay_conv`

## Requirements
- R1: While `rst` is high at a clock edge, the smoother state, `dly_valid` and `dly_out` all become 0.
- R2: Each clock edge with `ctl_valid` high updates a 16-bit smoother state s to s + floor(((ctl_code << 4) - s) / 16). The smoothed value is f = s >> 4. With `ctl_valid` low, s does not change.
- R3: Bits [11:9] of f give the octave number, bits [8:3] give the table index i, and bits [2:0] give the fraction p.
- R4: Table entry T[i], for i from 0 to 64, equals round(5859 * 256 * 2^(-i/64)). T[64] is therefore half of T[0].
- R5: The interpolated value is v = T[i] - floor((T[i] - T[i+1]) * p / 8).
- R6: The output is v when the octave is 0. Otherwise it is floor((v + 2^(oct-1)) / 2^oct), so the fraction bits are kept and the last bit is rounded.
- R7: After an edge that samples `ctl_valid` high, `dly_valid` is high, together with the matching `dly_out`, following the second edge after it. `dly_valid` is high for exactly one cycle per accepted code.
- R8: `dly_out` keeps its last value in any cycle in which `dly_valid` is low.
- R9: For every smoothed value f, `dly_out`/256 lies within one cent of 5859 * 2^(-f/512) samples.
- R10: A smoothed value of 0 yields exactly 5859.0 samples (1499904). `dly_out` never exceeds that value, and a settled full-scale code yields about 23 samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_valid | input | 1 | Control code strobe |
| ctl_code | input | 12 | Unsigned pitch control code |
| dly_valid | output | 1 | Delay result strobe |
| dly_out | output | 21 | Delay in samples, 13 integer and 8 fractional bits |

## Verification
The smoother state is not visible at the ports, but any error in it shifts every later delay value. Such an error therefore shows at `dly_out` on the next accepted code, and the reference model catches it three edges after the code is sampled. A wrong table entry, fraction weighting or rounding bit shows as a value mismatch on the first code whose smoothed value lands in the affected segment or octave. The ramp phase sweeps every segment and octave so that each of these faults is reached. A stray or missing strobe breaks the per-cycle comparison of `dly_valid` at once.

// File: rtl/pdc_pkg.sv
package pdc_pkg;

    localparam int CTL_W     = 12;
    localparam int OCT_W     = 3;
    localparam int IDX_W     = 6;
    localparam int SUB_W     = CTL_W - OCT_W - IDX_W;
    localparam int OUT_FRAC  = 8;
    localparam int BASE_DLY  = 5859;
    localparam int INT_W     = $clog2(BASE_DLY + 1);
    localparam int DLY_W     = INT_W + OUT_FRAC;
    localparam int N_ENT     = 1 << IDX_W;
    localparam int DLY_MAX   = BASE_DLY << OUT_FRAC;

    typedef logic [DLY_W-1:0] dly_t;

    typedef struct packed {
        logic [OCT_W-1:0] oct;
        logic [IDX_W-1:0] idx;
        logic [SUB_W-1:0] sub;
    } pitch_t;

    typedef struct packed {
        logic [OCT_W-1:0] oct;
        logic [SUB_W-1:0] sub;
        dly_t             near_ent;
        dly_t             far_ent;
    } seg_t;

    // lowest-octave entry: base * 2^(-i/N) in OUT_FRAC fixed point
    function automatic int ent_val(int i);
        real r;
        r = real'(BASE_DLY) * real'(1 << OUT_FRAC) * (2.0 ** (-real'(i) / real'(N_ENT)));
        return $rtoi(r + 0.5);
    endfunction

    function automatic dly_t round_shift(dly_t v, logic [OCT_W-1:0] s);
        logic [DLY_W:0] t;
        if (s == '0) return v;
        t = {1'b0, v} + ((DLY_W+1)'(1) << (s - 1'b1));
        return dly_t'(t >> s);
    endfunction

endpackage

// File: rtl/pdc_smooth.sv
module pdc_smooth
    import pdc_pkg::*;
#(
    parameter int K = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [CTL_W-1:0] in_code,
    output logic             out_valid,
    output pitch_t           out_pitch
);
    localparam int ACC_W = CTL_W + K;
    localparam logic [ACC_W-1:0] ACC_TOP = ACC_W'(((1 << CTL_W) - 1) << K);

    logic [ACC_W-1:0]        acc_q;
    logic signed [ACC_W+1:0] diff;
    logic [ACC_W-1:0]        step;

    always_comb begin
        diff = $signed({2'b00, in_code, {K{1'b0}}}) - $signed({2'b00, acc_q});
        step = ACC_W'(diff >>> K);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q     <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) acc_q <= acc_q + step;
        end
    end

    assign out_pitch = pitch_t'(acc_q[ACC_W-1:K]);

    // R2: state only moves on an accepted code
    p_acc_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(acc_q));
    // R2: state never passes the scaled full-scale code
    p_acc_range_r2: assert property (@(posedge clk) disable iff (rst)
        acc_q <= ACC_TOP);
    // R2: a code above the state never pulls it down
    p_acc_dir_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && ({in_code, {K{1'b0}}} >= acc_q)) |=> acc_q >= $past(acc_q));

endmodule

// File: rtl/pdc_lookup.sv
module pdc_lookup
    import pdc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   in_valid,
    input  pitch_t in_pitch,
    output logic   out_valid,
    output seg_t   out_seg
);
    dly_t tbl [N_ENT+1];

    for (genvar g = 0; g <= N_ENT; g++) begin : g_tbl
        assign tbl[g] = dly_t'(ent_val(g));
    end

    logic [IDX_W:0] idx_lo;
    logic [IDX_W:0] idx_hi;

    always_comb begin
        idx_lo = {1'b0, in_pitch.idx};
        idx_hi = idx_lo + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_seg   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_seg.oct      <= in_pitch.oct;
                out_seg.sub      <= in_pitch.sub;
                out_seg.near_ent <= tbl[idx_lo];
                out_seg.far_ent  <= tbl[idx_hi];
            end
        end
    end

    // R4: neighbours are ordered, longer delay first
    p_seg_order_r4: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_seg.near_ent > out_seg.far_ent);
    // R4: one table step is a ratio of about 2^(1/64), under 1/64 of the entry
    p_seg_step_r4: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_seg.near_ent - out_seg.far_ent) <= (out_seg.near_ent >> 6));

endmodule

// File: rtl/pdc_scale.sv
module pdc_scale
    import pdc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    input  seg_t in_seg,
    output logic out_valid,
    output dly_t out_dly
);
    localparam int PROD_W = DLY_W + SUB_W;

    dly_t              delta;
    logic [PROD_W-1:0] prod;
    dly_t              interp;

    always_comb begin
        delta  = in_seg.near_ent - in_seg.far_ent;
        prod   = PROD_W'(delta) * PROD_W'(in_seg.sub);
        interp = in_seg.near_ent - dly_t'(prod >> SUB_W);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_dly   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_dly <= round_shift(interp, in_seg.oct);
        end
    end

    // R5: the interpolated point stays inside its segment
    p_interp_bounds_r5: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> (interp <= in_seg.near_ent && interp > in_seg.far_ent));
    // R8: no strobe, no change
    p_out_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_dly));
    // R10: never longer than the base delay
    p_out_max_r10: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_dly <= dly_t'(DLY_MAX));

endmodule

// File: rtl/pitch_delay_conv.sv
module pitch_delay_conv
    import pdc_pkg::*;
#(
    parameter int SMOOTH_K = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctl_valid,
    input  logic [CTL_W-1:0] ctl_code,
    output logic             dly_valid,
    output logic [DLY_W-1:0] dly_out
);
    logic   sm_valid;
    pitch_t sm_pitch;
    logic   lk_valid;
    seg_t   lk_seg;

    pdc_smooth #(.K(SMOOTH_K)) u_smooth (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (ctl_valid),
        .in_code   (ctl_code),
        .out_valid (sm_valid),
        .out_pitch (sm_pitch)
    );

    pdc_lookup u_lookup (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (sm_valid),
        .in_pitch  (sm_pitch),
        .out_valid (lk_valid),
        .out_seg   (lk_seg)
    );

    pdc_scale u_scale (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (lk_valid),
        .in_seg    (lk_seg),
        .out_valid (dly_valid),
        .out_dly   (dly_out)
    );

    // R7: each strobe is one cycle wide when codes arrive one cycle apart
    p_strobe_pipe_r7: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && !sm_valid) |=> (dly_valid && !lk_valid));

endmodule

// File: tb/pitch_delay_conv_tb_top.sv
module pitch_delay_conv_tb_top;

    localparam int K     = 4;
    localparam int BASE  = 5859;
    localparam int WDOG  = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctl_valid = 1'b0;
    logic [11:0] ctl_code = '0;
    logic        dly_valid;
    logic [20:0] dly_out;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 0;
    string tag = "R1";

    always #4 clk = ~clk;

    pitch_delay_conv #(.SMOOTH_K(K)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .ctl_valid (ctl_valid),
        .ctl_code  (ctl_code),
        .dly_valid (dly_valid),
        .dly_out   (dly_out)
    );

    int tbl [65];
    initial begin
        for (int i = 0; i <= 64; i++)
            tbl[i] = $rtoi(real'(BASE) * 256.0 * $pow(2.0, -real'(i) / 64.0) + 0.5);
    end

    function automatic int expect_delay(int f);
        int oct, idx, sub, lo, hi, v;
        oct = f / 512;
        idx = (f / 8) % 64;
        sub = f % 8;
        lo  = tbl[idx];
        hi  = tbl[idx + 1];
        v   = lo - (((lo - hi) * sub) / 8);
        if (oct > 0) v = (v + (1 << (oct - 1))) >> oct;
        return v;
    endfunction

    // reference: smoother state, three-deep strobe history
    int acc_m = 0;
    int p0d, p1d, p2d, p0f, p1f, p2f;
    bit p0v, p1v, p2v;
    int exp_out = 0;

    always @(posedge clk) begin
        int diff;
        if (rst) begin
            acc_m = 0; p0v = 0; p1v = 0; p2v = 0; exp_out = 0;
        end else begin
            p2v = p1v; p2d = p1d; p2f = p1f;
            p1v = p0v; p1d = p0d; p1f = p0f;
            p0v = 0;
            if (ctl_valid) begin
                diff  = (int'(ctl_code) << K) - acc_m;
                acc_m = acc_m + (diff >>> K);
                p0f   = acc_m >>> K;
                p0d   = expect_delay(p0f);
                p0v   = 1;
            end
            if (p2v) exp_out = p2d;
        end
        cyc++;
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        real ideal, cents;
        if (!rst && !done) begin
            checks++;
            if (dly_valid !== p2v) begin
                failures++;
                $display("FAIL R7 (%s) dly_valid actual=%0b expected=%0b", tag, dly_valid, p2v);
            end
            checks++;
            if (int'(dly_out) !== exp_out) begin
                failures++;
                if (p2v)
                    $display("FAIL R4 R5 R6 (%s) dly_out actual=%0d expected=%0d f=%0d",
                             tag, dly_out, exp_out, p2f);
                else
                    $display("FAIL R8 (%s) held dly_out actual=%0d expected=%0d", tag, dly_out, exp_out);
            end
            if (p2v) begin
                ideal = real'(BASE) * $pow(2.0, -real'(p2f) / 512.0);
                cents = 1200.0 * $ln((real'(dly_out) / 256.0) / ideal) / $ln(2.0);
                checks++;
                if (cents > 1.0 || cents < -1.0) begin
                    failures++;
                    $display("FAIL R9 cents actual=%f expected=0 (+-1) f=%0d", cents, p2f);
                end
            end
        end
    end

    always @(posedge clk) begin
        if (cyc > WDOG && !done) begin
            done = 1;
            failures++;
            $display("FAIL R7 watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic send(input int code, input int n, input int gap);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            ctl_valid = 1'b1;
            ctl_code  = 12'(code);
            for (int g = 0; g < gap; g++) begin
                @(negedge clk);
                ctl_valid = 1'b0;
            end
        end
        @(negedge clk);
        ctl_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic check_val(input string req, input int act, input int lo, input int hi);
        checks++;
        if (act < lo || act > hi) begin
            failures++;
            $display("FAIL %s actual=%0d expected=[%0d..%0d]", req, act, lo, hi);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        tag = "R1";
        check_val("R1 dly_valid after reset", int'(dly_valid), 0, 0);
        check_val("R1 dly_out after reset", int'(dly_out), 0, 0);

        tag = "R10";
        send(0, 20, 0);
        idle(4);
        check_val("R10 zero code delay", int'(dly_out), BASE * 256, BASE * 256);

        tag = "R8";
        idle(10);
        check_val("R8 hold after idle", int'(dly_out), BASE * 256, BASE * 256);

        tag = "R2";
        send(4095, 1, 0);
        idle(6);
        check_val("R2 first step from zero state", int'(dly_out),
                  expect_delay(255), expect_delay(255));
        send(4095, 200, 0);
        idle(4);
        tag = "R10";
        check_val("R10 full-scale delay near 23 samples", int'(dly_out), 22 * 256, 24 * 256);

        tag = "R6";
        for (int o = 7; o >= 0; o--) send(o * 512 + 100, 120, 1);

        tag = "R3";
        send(1234, 150, 2);
        send(3333, 150, 0);

        tag = "R4";
        for (int c = 4088; c >= 8; c -= 520) send(c, 100, 0);

        tag = "R5";
        for (int c = 0; c < 4096; c++) begin
            @(negedge clk);
            ctl_valid = 1'b1;
            ctl_code  = 12'(c);
        end
        @(negedge clk);
        ctl_valid = 1'b0;

        tag = "R7";
        for (int k = 0; k < 2000; k++) begin
            @(negedge clk);
            ctl_valid = 1'($urandom_range(0, 1));
            ctl_code  = 12'($urandom_range(0, 4095));
        end
        @(negedge clk);
        ctl_valid = 1'b0;
        idle(6);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule